// File: doc/BRIEF.md
# Command Ring Consumer Engine

This block sits on the device side of a host command ring. Software places command cells in memory and links each cell to the next one. The cell at the end of the list points back to the head, which closes the ring. Software then moves a producer index forward through a small register interface. While its consumer index differs from the producer index, the engine walks the list. For each cell it fetches three words through a valid/ready memory read port: the control word, the descriptor and the next-cell pointer. It checks the byte checksum of the first two words. It then moves the consumer index forward and sends a 32-bit status word back to a programmed address through a valid/ready write port.

The read request and the status write both obey valid/ready rules. Once valid is raised, the address and data stay constant until the same cycle in which ready is seen high. The engine raises the read response ready only while it waits for a response, and it has at most one read outstanding. A checksum failure or a failed read stops the engine. Only a restart, which is a self-clearing command bit, moves the engine on again. A restart sets the consumer index to zero and the walk position to the head.

Top module: `cmd_ring_engine`

## Requirements
- R1: After reset the consumer index is 0, the restart bit reads 0, the ring-size register reads DEPTH (32), the control register reads 0x07, the status register reads 0, ring_drained is 1 and ring_full is 0.
- R2: A write to the producer register (address 0) stores the value ANDed with ring size minus one. The engine consumes cells while the consumer index differs from the producer index. ring_drained is high exactly when the two are equal.
- R3: ring_full is high exactly when the consumer index equals (producer index + 1) AND (ring size − 1).
- R4: Each cell is read at offset +0 (control), then +8 (descriptor), then +24 (next-cell pointer, low address bits). The first cell after reset or restart is the one at the head register (address 4). Every later cell is the one that the previous cell's pointer names.
- R5: The consumer index goes up by one, modulo the ring size, for each fully fetched cell, and it wraps from size − 1 to 0.
- R6: A word passes its checksum when bits 63:56 equal the XOR of its seven lower bytes. Control bits [1:0] choose which words are checked: 0 none, 1 control word only, 2 descriptor only, 3 both.
- R7: A checked word that fails sets status bit 16. If control bit 2 is 1, the engine then stops and the consumer index holds until a restart. If control bit 2 is 0, the walk goes on.
- R8: A read response with the error flag set sets status bit 17 and stops the engine until a restart.
- R9: The status word holds the consumer index in bits 15:0, the checksum flag in bit 16, the read-error flag in bit 17 and the walker state code in bits 21:20 (0 idle, 1 request, 2 response, 3 write-back). It is written to the status address (register 5) after every consumed cell and after every stop. swr_valid and swr_data stay constant until swr_ready is seen.
- R10: Writing 1 to bit 0 of register 2 requests a restart, and the bit reads 1 until the restart is done. A restart waits for any cell in flight to finish. It then clears the consumer index and both flags and returns to the head. If control bit 4 is 1, the bit stays set until a status write-back for the restart has been accepted.
- R11: With control bit 3 set, done_evt pulses for one cycle for every accepted cell write-back. It stays low when the bit is clear and for restart write-backs.
- R12: mrd_req_valid and mrd_req_addr stay constant until mrd_req_ready is seen. mrd_rsp_ready is high only while the engine waits for a response.
- R13: Control bits [7:5] hold a cell-size code, log2(size/64), that reads back as written and does not change the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mrd_req_valid | output | 1 | Read request valid |
| mrd_req_ready | input | 1 | Read request ready |
| mrd_req_addr | output | AW | Read byte address |
| mrd_rsp_valid | input | 1 | Read response valid |
| mrd_rsp_ready | output | 1 | Read response ready |
| mrd_rsp_data | input | 64 | Read data, big-endian word value |
| mrd_rsp_err | input | 1 | Read response error |
| swr_valid | output | 1 | Status write valid |
| swr_ready | input | 1 | Status write ready |
| swr_addr | output | AW | Status write address |
| swr_data | output | 32 | Status word |
| done_evt | output | 1 | Cell-consumed event pulse |
| ring_full | output | 1 | Ring full indication |
| ring_drained | output | 1 | Consumer index equals producer index |

## Verification
Two functions can fall in the same cycle: a restart request and a cell fetch that is already under way. The bench forces this by holding the read port not-ready so that a fetch stays stuck in its request phase, and then writing the restart bit. It judges the result in three ways. The restart bit must still read 1 while the fetch is pending. The cell in flight must complete with its own write-back. After that the fetch log must show the walk starting again at the head, and the final consumer index must be correct.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_REQ  = 2'd1,
    W_RSP  = 2'd2,
    W_WB   = 2'd3
  } walk_st_e;

  localparam logic [2:0] RA_PROD   = 3'd0;
  localparam logic [2:0] RA_CTRL   = 3'd1;
  localparam logic [2:0] RA_KICK   = 3'd2;
  localparam logic [2:0] RA_DEPTH  = 3'd3;
  localparam logic [2:0] RA_HEAD   = 3'd4;
  localparam logic [2:0] RA_WBADDR = 3'd5;
  localparam logic [2:0] RA_STAT   = 3'd6;

  // bit 7..5 cell size code, 4 write-back on restart, 3 event enable,
  // 2 halt on checksum error, 1..0 check mode
  typedef struct packed {
    logic [2:0] cell_sz;
    logic       wb_on_rst;
    logic       evt_en;
    logic       halt_en;
    logic [1:0] chk_mode;
  } ring_ctrl_t;

  localparam int STAT_XS_BIT  = 16;
  localparam int STAT_CP_BIT  = 17;
  localparam int STAT_FSM_LSB = 20;

endpackage

// File: rtl/cmd_ring_xsum.sv
module cmd_ring_xsum #(
  parameter int NB = 8
) (
  input  logic [8*NB-1:0] word,
  output logic            sum_ok
);
  logic [7:0] part [NB];

  assign part[0] = 8'h00;
  for (genvar b = 0; b < NB - 1; b++) begin : g_fold
    assign part[b+1] = part[b] ^ word[8*b +: 8];
  end

  assign sum_ok = (part[NB-1] == word[8*(NB-1) +: 8]);
endmodule

// File: rtl/cmd_ring_regs.sv
module cmd_ring_regs
  import cmd_ring_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 32,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          restart_done,
  input  logic [31:0]   status,
  output logic [IW-1:0] pi,
  output logic [IW-1:0] mask,
  output ring_ctrl_t    ctrl,
  output logic [AW-1:0] head,
  output logic [AW-1:0] wb_addr,
  output logic          restart_busy
);
  localparam int CW = IW + 1;

  logic [CW-1:0] depth_q;

  assign mask = IW'(depth_q - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pi           <= '0;
      depth_q      <= CW'(DEPTH);
      ctrl         <= '{cell_sz: 3'd0, wb_on_rst: 1'b0, evt_en: 1'b0,
                        halt_en: 1'b1, chk_mode: 2'd3};
      head         <= '0;
      wb_addr      <= '0;
      restart_busy <= 1'b0;
    end else begin
      if (restart_done) restart_busy <= 1'b0;
      if (wr_en) begin
        case (addr)
          RA_PROD:   pi      <= wdata[IW-1:0] & mask;
          RA_CTRL:   ctrl    <= ring_ctrl_t'(wdata[7:0]);
          RA_KICK:   if (wdata[0] && !restart_busy) restart_busy <= 1'b1;
          RA_DEPTH:  depth_q <= wdata[CW-1:0];
          RA_HEAD:   head    <= AW'(wdata);
          RA_WBADDR: wb_addr <= AW'(wdata);
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_PROD:   rdata = 32'(pi);
      RA_CTRL:   rdata = 32'(ctrl);
      RA_KICK:   rdata = 32'(restart_busy);
      RA_DEPTH:  rdata = 32'(depth_q);
      RA_HEAD:   rdata = 32'(head);
      RA_WBADDR: rdata = 32'(wb_addr);
      RA_STAT:   rdata = status;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/cmd_ring_walker.sv
module cmd_ring_walker
  import cmd_ring_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] pi,
  input  logic [IW-1:0] mask,
  input  ring_ctrl_t    ctrl,
  input  logic [AW-1:0] head,
  input  logic [AW-1:0] wb_addr,
  input  logic          restart_busy,
  output logic          restart_done,
  output logic          mrd_req_valid,
  input  logic          mrd_req_ready,
  output logic [AW-1:0] mrd_req_addr,
  input  logic          mrd_rsp_valid,
  output logic          mrd_rsp_ready,
  input  logic [63:0]   mrd_rsp_data,
  input  logic          mrd_rsp_err,
  input  logic          sum_ok,
  output logic          swr_valid,
  input  logic          swr_ready,
  output logic [AW-1:0] swr_addr,
  output logic [31:0]   swr_data,
  output logic          done_evt,
  output logic [IW-1:0] ci,
  output logic          halted,
  output logic [31:0]   status
);
  walk_st_e      st;
  logic [1:0]    wsel;
  logic [AW-1:0] cur;
  logic          at_head, xs_err, cp_err, rst_wb;
  logic [AW-1:0] cell_base, word_off;
  logic          chk_this;

  assign cell_base = at_head ? head : cur;

  always_comb begin
    case (wsel)
      2'd0:    word_off = AW'(0);
      2'd1:    word_off = AW'(8);
      default: word_off = AW'(24);
    endcase
  end

  assign chk_this      = (wsel == 2'd0) ? ctrl.chk_mode[0] : ctrl.chk_mode[1];
  assign mrd_req_valid = (st == W_REQ);
  assign mrd_req_addr  = cell_base + word_off;
  assign mrd_rsp_ready = (st == W_RSP);
  assign swr_valid     = (st == W_WB);
  assign swr_addr      = wb_addr;
  assign swr_data      = status;

  always_comb begin
    status                           = '0;
    status[IW-1:0]                   = ci;
    status[STAT_XS_BIT]              = xs_err;
    status[STAT_CP_BIT]              = cp_err;
    status[STAT_FSM_LSB +: 2]        = st;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= W_IDLE;
      wsel         <= 2'd0;
      cur          <= '0;
      at_head      <= 1'b1;
      ci           <= '0;
      xs_err       <= 1'b0;
      cp_err       <= 1'b0;
      halted       <= 1'b0;
      rst_wb       <= 1'b0;
      restart_done <= 1'b0;
      done_evt     <= 1'b0;
    end else begin
      restart_done <= 1'b0;
      done_evt     <= 1'b0;
      case (st)
        W_IDLE: begin
          if (restart_busy && !restart_done) begin
            ci      <= '0;
            at_head <= 1'b1;
            xs_err  <= 1'b0;
            cp_err  <= 1'b0;
            halted  <= 1'b0;
            if (ctrl.wb_on_rst) begin
              rst_wb <= 1'b1;
              st     <= W_WB;
            end else begin
              restart_done <= 1'b1;
            end
          end else if (!halted && (ci != pi)) begin
            wsel <= 2'd0;
            st   <= W_REQ;
          end
        end
        W_REQ: if (mrd_req_ready) st <= W_RSP;
        W_RSP: begin
          if (mrd_rsp_valid) begin
            if (mrd_rsp_err) begin
              cp_err <= 1'b1;
              halted <= 1'b1;
              st     <= W_WB;
            end else if (wsel != 2'd2) begin
              if (chk_this && !sum_ok) begin
                xs_err <= 1'b1;
                if (ctrl.halt_en) begin
                  halted <= 1'b1;
                  st     <= W_WB;
                end else begin
                  wsel <= wsel + 2'd1;
                  st   <= W_REQ;
                end
              end else begin
                wsel <= wsel + 2'd1;
                st   <= W_REQ;
              end
            end else begin
              cur     <= AW'(mrd_rsp_data);
              at_head <= 1'b0;
              ci      <= (ci + IW'(1)) & mask;
              st      <= W_WB;
            end
          end
        end
        W_WB: begin
          if (swr_ready) begin
            st <= W_IDLE;
            if (rst_wb) begin
              rst_wb       <= 1'b0;
              restart_done <= 1'b1;
            end else if (ctrl.evt_en) begin
              done_evt <= 1'b1;
            end
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_ring_engine.sv
module cmd_ring_engine
  import cmd_ring_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mrd_req_valid,
  input  logic          mrd_req_ready,
  output logic [AW-1:0] mrd_req_addr,
  input  logic          mrd_rsp_valid,
  output logic          mrd_rsp_ready,
  input  logic [63:0]   mrd_rsp_data,
  input  logic          mrd_rsp_err,
  output logic          swr_valid,
  input  logic          swr_ready,
  output logic [AW-1:0] swr_addr,
  output logic [31:0]   swr_data,
  output logic          done_evt,
  output logic          ring_full,
  output logic          ring_drained
);
  localparam int IW = $clog2(DEPTH);

  logic [IW-1:0] pi, mask, ci;
  ring_ctrl_t    ctrl;
  logic [AW-1:0] head, wb_addr;
  logic          restart_busy, restart_done, halted, sum_ok;
  logic [31:0]   status;

  cmd_ring_regs #(.AW(AW), .DEPTH(DEPTH), .IW(IW)) regs_i (
    .clk, .rst_n,
    .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .restart_done, .status, .pi, .mask, .ctrl, .head, .wb_addr, .restart_busy
  );

  cmd_ring_xsum #(.NB(8)) xsum_i (.word(mrd_rsp_data), .sum_ok);

  cmd_ring_walker #(.AW(AW), .IW(IW)) walk_i (
    .clk, .rst_n, .pi, .mask, .ctrl, .head, .wb_addr, .restart_busy,
    .restart_done, .mrd_req_valid, .mrd_req_ready, .mrd_req_addr,
    .mrd_rsp_valid, .mrd_rsp_ready, .mrd_rsp_data, .mrd_rsp_err, .sum_ok,
    .swr_valid, .swr_ready, .swr_addr, .swr_data, .done_evt, .ci, .halted,
    .status
  );

  assign ring_full    = (ci == ((pi + IW'(1)) & mask));
  assign ring_drained = (ci == pi);
endmodule

// File: rtl/cmd_ring_engine_chk.sv
module cmd_ring_engine_chk #(
  parameter int AW = 32,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mrd_req_valid,
  input logic          mrd_req_ready,
  input logic [AW-1:0] mrd_req_addr,
  input logic          swr_valid,
  input logic          swr_ready,
  input logic [31:0]   swr_data,
  input logic [IW-1:0] ci,
  input logic [IW-1:0] mask,
  input logic          halted,
  input logic          restart_busy,
  input logic          done_evt
);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_req_valid && !mrd_req_ready |=> mrd_req_valid && $stable(mrd_req_addr));

  p_wb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    swr_valid && !swr_ready |=> swr_valid && $stable(swr_data));

  p_ci_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ci != $past(ci)) |-> ((ci == (($past(ci) + IW'(1)) & mask)) || (ci == '0)));

  p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !restart_busy |=> $stable(ci));

  p_evt_after_wb_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> $past(swr_valid && swr_ready));
endmodule

bind cmd_ring_engine cmd_ring_engine_chk #(.AW(AW), .IW(IW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mrd_req_valid(mrd_req_valid),
  .mrd_req_ready(mrd_req_ready), .mrd_req_addr(mrd_req_addr),
  .swr_valid(swr_valid), .swr_ready(swr_ready), .swr_data(swr_data),
  .ci(ci), .mask(mask), .halted(halted), .restart_busy(restart_busy),
  .done_evt(done_evt)
);

// File: tb/cmd_ring_engine_tb_top.sv
`timescale 1ns/1ps
module cmd_ring_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mrd_req_valid, mrd_rsp_ready, swr_valid, done_evt;
  logic        ring_full, ring_drained;
  logic [31:0] mrd_req_addr, swr_addr, swr_data;
  logic        mrd_req_ready, mrd_rsp_valid, mrd_rsp_err, swr_ready;
  logic [63:0] mrd_rsp_data;

  logic        mem_rdy = 1'b1, wb_rdy = 1'b1;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [63:0] mem [0:511];
  logic        pend;
  logic [31:0] pend_addr;
  logic [31:0] flog [0:255];
  int          nlog, wb_cnt, evt_cnt;
  logic [31:0] wb_last, wb_last_addr;
  int          n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  cmd_ring_engine dut_i (
    .clk, .rst_n, .reg_wr_en, .reg_addr, .reg_wdata, .reg_rdata,
    .mrd_req_valid, .mrd_req_ready, .mrd_req_addr, .mrd_rsp_valid,
    .mrd_rsp_ready, .mrd_rsp_data, .mrd_rsp_err, .swr_valid, .swr_ready,
    .swr_addr, .swr_data, .done_evt, .ring_full, .ring_drained
  );

  assign mrd_req_ready = mem_rdy;
  assign mrd_rsp_valid = pend;
  assign mrd_rsp_data  = mem[pend_addr[11:3]];
  assign mrd_rsp_err   = pend && (pend_addr == err_addr);
  assign swr_ready     = wb_rdy;

  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; pend_addr <= '0; nlog <= 0;
      wb_cnt <= 0; evt_cnt <= 0; wb_last <= '0; wb_last_addr <= '0;
    end else begin
      if (mrd_rsp_valid && mrd_rsp_ready) pend <= 1'b0;
      if (mrd_req_valid && mrd_req_ready) begin
        pend <= 1'b1;
        pend_addr <= mrd_req_addr;
        if (mrd_req_addr[4:0] == 5'd0 && nlog < 256) begin
          flog[nlog] <= mrd_req_addr;
          nlog <= nlog + 1;
        end
      end
      if (swr_valid && swr_ready) begin
        wb_cnt <= wb_cnt + 1; wb_last <= swr_data; wb_last_addr <= swr_addr;
      end
      if (done_evt) evt_cnt <= evt_cnt + 1;
    end
  end

  function automatic logic [31:0] caddr(input int k);
    return 32'h200 + 32'(((k * 3) % 8) * 32);
  endfunction

  function automatic logic [63:0] mkw(input logic [55:0] body);
    logic [7:0] x = 8'h00;
    for (int b = 0; b < 7; b++) x ^= body[8*b +: 8];
    return {x, body};
  endfunction

  function automatic logic [31:0] stw(input int ci, input bit xs, input bit cp, input int fsm);
    return 32'(ci) | (32'(xs) << 16) | (32'(cp) << 17) | (32'(fsm) << 20);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic build_ring();
    for (int i = 0; i < 512; i++) mem[i] = '0;
    for (int k = 0; k < 8; k++) begin
      mem[(caddr(k) >> 3) + 0] = mkw({8'hC0, 48'(k)});
      mem[(caddr(k) >> 3) + 1] = mkw({8'hD5, 48'(k + 16)});
      mem[(caddr(k) >> 3) + 2] = 64'h1000 + 64'(k);
      mem[(caddr(k) >> 3) + 3] = 64'(caddr((k + 1) % 8));
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (ring_drained && !swr_valid && !mrd_req_valid && !pend) quiet++;
      else quiet = 0;
      if (quiet >= 3) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_rd(3'd2, d); check("R1 restart bit", d, 0);
    reg_rd(3'd3, d); check("R1 ring size", d, 32);
    reg_rd(3'd1, d); check("R1 control", d, 32'h07);
    reg_rd(3'd6, d); check("R1 status", d, 0);
    check("R1 drained/full", {ring_drained, ring_full}, 2'b10);
  endtask

  task automatic t_basic_walk();
    int l0 = nlog, w0 = wb_cnt, e0 = evt_cnt;
    logic [31:0] d;
    reg_wr(3'd0, 3);
    wait_idle();
    reg_rd(3'd6, d); check("R5 ci after 3 cells", d, stw(3, 0, 0, 0));
    check("R9 writeback count", wb_cnt - w0, 3);
    check("R9 writeback word", wb_last, stw(3, 0, 0, 3));
    check("R9 writeback addr", wb_last_addr, 32'h0F00);
    check("R11 event pulses", evt_cnt - e0, 3);
    for (int j = 0; j < 3; j++) check("R4 linked order", flog[l0 + j], caddr(j));
  endtask

  task automatic t_pi_mask();
    logic [31:0] d;
    reg_wr(3'd0, 13);
    reg_rd(3'd0, d); check("R2 producer masked", d, 5);
    wait_idle();
    reg_rd(3'd6, d); check("R2 ci reaches pi", d, stw(5, 0, 0, 0));
    check("R2 drained", ring_drained, 1);
  endtask

  task automatic t_wrap_full();
    int l0;
    logic [31:0] d;
    mem_rdy = 1'b0;
    l0 = nlog;
    reg_wr(3'd0, 4);
    wait_cyc(3);
    check("R3 full with ci=pi+1", ring_full, 1);
    mem_rdy = 1'b1;
    wait_idle();
    reg_rd(3'd6, d); check("R5 wrap to 4", d, stw(4, 0, 0, 0));
    check("R3 not full when drained", ring_full, 0);
    for (int j = 0; j < 7; j++) check("R4 order across wrap", flog[l0 + j], caddr((5 + j) % 8));
  endtask

  task automatic t_wb_backpressure();
    logic [31:0] d;
    wb_rdy = 1'b0;
    reg_wr(3'd0, 5);
    wait_cyc(12);
    check("R9 valid held", swr_valid, 1);
    reg_rd(3'd6, d); check("R9 status in write-back", d, stw(5, 0, 0, 3));
    check("R12 no read while stalled", mrd_req_valid, 0);
    wb_rdy = 1'b1;
    wait_idle();
    reg_rd(3'd6, d); check("R9 idle after accept", d, stw(5, 0, 0, 0));
  endtask

  task automatic t_xsum_halt();
    logic [31:0] d;
    mem[(caddr(5) >> 3) + 1] ^= 64'h1;
    reg_wr(3'd0, 7);
    wait_cyc(40);
    reg_rd(3'd6, d); check("R7 halted, ci frozen", d, stw(5, 1, 0, 0));
    check("R7 halt writeback", wb_last, stw(5, 1, 0, 3));
    check("R7 not drained", ring_drained, 0);
  endtask

  task automatic t_restart_wb();
    int e0;
    logic [31:0] d;
    reg_wr(3'd0, 0);
    reg_wr(3'd1, 32'h1F);
    e0 = evt_cnt;
    wb_rdy = 1'b0;
    reg_wr(3'd2, 1);
    wait_cyc(5);
    reg_rd(3'd2, d); check("R10 bit held until wb", d, 1);
    wb_rdy = 1'b1;
    wait_cyc(6);
    reg_rd(3'd2, d); check("R10 bit self-clears", d, 0);
    reg_rd(3'd6, d); check("R10 ci and flags cleared", d, stw(0, 0, 0, 0));
    check("R10 restart writeback", wb_last, stw(0, 0, 0, 3));
    check("R11 no event on restart wb", evt_cnt - e0, 0);
  endtask

  task automatic t_modes();
    logic [31:0] d;
    reg_wr(3'd1, 32'h0D);
    reg_wr(3'd0, 6);
    wait_idle();
    reg_rd(3'd6, d); check("R6 ctrl-only mode skips descriptor", d, stw(6, 0, 0, 0));
    mem[(caddr(6) >> 3) + 0] ^= 64'h1;
    reg_wr(3'd1, 32'h0B);
    reg_wr(3'd0, 7);
    wait_idle();
    reg_rd(3'd6, d); check("R7 flag without halt", d, stw(7, 1, 0, 0));
  endtask

  task automatic t_read_err();
    logic [31:0] d;
    build_ring();
    err_addr = caddr(0) + 8;
    reg_wr(3'd1, 32'h0F);
    reg_wr(3'd2, 1);
    wait_cyc(40);
    reg_rd(3'd6, d); check("R8 read error halts", d, stw(0, 0, 1, 0));
    check("R8 error writeback", wb_last, stw(0, 0, 1, 3));
  endtask

  task automatic t_restart_inflight();
    int l0, w0;
    logic [31:0] d;
    err_addr = 32'hFFFF_FFFF;
    mem_rdy = 1'b0;
    reg_wr(3'd2, 1);
    wait_cyc(5);
    l0 = nlog; w0 = wb_cnt;
    reg_wr(3'd2, 1);
    reg_rd(3'd2, d); check("R10 restart pending during fetch", d, 1);
    mem_rdy = 1'b1;
    wait_idle();
    reg_rd(3'd6, d); check("R10 re-walk after restart", d, stw(7, 0, 0, 0));
    check("R10 writebacks incl. in-flight cell", wb_cnt - w0, 8);
    check("R10 in-flight cell first", flog[l0], caddr(0));
    for (int j = 0; j < 7; j++) check("R4 walk from head again", flog[l0 + 1 + j], caddr(j));
  endtask

  task automatic t_size_code();
    int e0;
    logic [31:0] d;
    reg_wr(3'd1, 32'h67);
    reg_rd(3'd1, d); check("R13 size code readback", d, 32'h67);
    e0 = evt_cnt;
    reg_wr(3'd0, 1);
    wait_idle();
    reg_rd(3'd6, d); check("R13 walk unaffected", d, stw(1, 0, 0, 0));
    check("R11 no event when disabled", evt_cnt - e0, 0);
  endtask

  initial begin
    build_ring();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    reg_wr(3'd3, 8);
    reg_wr(3'd4, caddr(0));
    reg_wr(3'd5, 32'h0F00);
    reg_wr(3'd1, 32'h0F);
    t_basic_walk();
    t_pi_mask();
    t_wrap_full();
    t_wb_backpressure();
    t_xsum_halt();
    t_restart_wb();
    t_modes();
    t_read_err();
    t_restart_inflight();
    t_size_code();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule